// File: doc/BRIEF.md
# Prescaled Backlight PWM Generator

This block drives a display backlight. It produces one pulse-width-modulated output and a separate backlight-enable pin, and it is set up through a byte-wide parallel register port that stands in for a host serial bus. A 7-bit prescaler divides the block clock to make a slow tick. An 8-bit position counter steps on that tick, so one period spans 256 ticks. The output is high from the start of each period for a time set by an 8-bit duty level.

The divider register holds both the prescale field and the run flag, with the run flag in bit 7. Host software changes the period in two steps. It first writes zero to the divider register, which stops the generator and holds it at the start of a period. It then writes the new divider with the run flag set. A new duty level written while the generator runs is held in the register and takes effect only at the next period boundary, so a period already under way is never cut short or stretched.

Top module: `bl_pwm`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, every register clears to zero. After reset, `pwm_out` and `bl_en` are low and all three registers read 0x00.
- R2: `rdata` is a combinational function of `addr`. It returns the last byte written at 0x4B (divider), 0x4E (duty) or 0x51 (backlight enable), and 0x00 at any other address. Writes take effect at the clock edge where `wr_en` is high.
- R3: In the divider register, bit 7 is the run flag and bits 6:0 are a field n. While running, the position counter advances once every n+1 clock cycles, for n = 0 through 127.
- R4: One PWM period lasts 256*(n+1) clock cycles. A period starts on the first cycle after the edge that sets the run flag, and `pwm_out` is high in that cycle when the level is non-zero.
- R5: With duty level L below 0xFF, `pwm_out` is high for the first L*(n+1) cycles of each period and low for the rest. L = 0x00 keeps it always low, and L = 0xFF keeps it always high while running.
- R6: A duty write made while running is applied at the next period boundary, that is, the edge where the position counter wraps from 255 to 0. A write landing on that same edge is applied at the boundary after. While stopped, the active level follows the duty register every cycle.
- R7: `bl_en` equals bit 0 of the register at 0x51 from the cycle after the write, whatever the PWM state is.
- R8: While the run flag is clear, `pwm_out` is low in the same cycle, and the prescaler and position counter are held at zero.
- R9: Writing 0x00 to the divider while running drives `pwm_out` low in the cycle right after the write. A following write with the run flag set starts a full new period with the new divider.
- R10: If the divider field is rewritten to a smaller value while running, the prescaler never counts beyond the new field. It ticks on the next cycle and continues with the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the base clock that the prescaler divides |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 8 | Register address for both write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| pwm_out | output | 1 | PWM backlight drive |
| bl_en | output | 1 | Backlight enable pin |

## Verification
The two functions that can fall in the same cycle are a duty-register write and the period-boundary load of that register into the active level. The bench times a duty write so that it lands exactly on the edge where the position counter wraps. It then checks that the period which follows still uses the old level and that the new level appears only one period later. A second collision, a divider rewrite arriving as the prescaler count sits above the new field, is provoked mid-run and judged against the per-cycle model.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;

    localparam int BYTE_W = 8;
    localparam int DIV_W  = 7;
    localparam int POS_W  = 8;

    localparam logic [BYTE_W-1:0] ADDR_DIV  = 8'h4B;
    localparam logic [BYTE_W-1:0] ADDR_DUTY = 8'h4E;
    localparam logic [BYTE_W-1:0] ADDR_BL   = 8'h51;

    typedef struct packed {
        logic             run;
        logic [DIV_W-1:0] div;
    } div_reg_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_DIV,
        SEL_DUTY,
        SEL_BL
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [BYTE_W-1:0] a);
        reg_sel_t s;
        case (a)
            ADDR_DIV:  s = SEL_DIV;
            ADDR_DUTY: s = SEL_DUTY;
            ADDR_BL:   s = SEL_BL;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic level_high(input logic [POS_W-1:0] pos,
                                        input logic [POS_W-1:0] lvl);
        return (lvl == {POS_W{1'b1}}) || (pos < lvl);
    endfunction

endpackage

// File: rtl/bl_pwm_regfile.sv
module bl_pwm_regfile
    import bl_pwm_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output div_reg_t      div_q,
    output logic [DW-1:0] duty_q,
    output logic [DW-1:0] bl_q,
    output logic [DW-1:0] rdata
);

    reg_sel_t wsel;
    reg_sel_t rsel;

    assign wsel = decode_addr(addr);
    assign rsel = wsel;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            duty_q <= '0;
            bl_q   <= '0;
        end else if (wr_en) begin
            case (wsel)
                SEL_DIV:  div_q  <= div_reg_t'(wdata);
                SEL_DUTY: duty_q <= wdata;
                SEL_BL:   bl_q   <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (rsel)
            SEL_DIV:  rdata = DW'(div_q);
            SEL_DUTY: rdata = duty_q;
            SEL_BL:   rdata = bl_q;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/bl_pwm_prescaler.sv
module bl_pwm_prescaler #(
    parameter int W = bl_pwm_pkg::DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic [W-1:0] cnt,
    output logic         tick
);

    logic at_limit;

    // >= rather than == so a shrinking field never lets the count run away
    assign at_limit = (cnt >= div);
    assign tick     = run && at_limit;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (at_limit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/bl_pwm_period.sv
module bl_pwm_period
    import bl_pwm_pkg::*;
#(
    parameter int W = POS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] duty_in,
    output logic [W-1:0] pos,
    output logic [W-1:0] act,
    output logic         pwm
);

    localparam logic [W-1:0] POS_LAST = {W{1'b1}};

    logic wrap;

    assign wrap = tick && (pos == POS_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
            act <= '0;
        end else if (!run) begin
            pos <= '0;
            act <= duty_in;
        end else if (tick) begin
            pos <= pos + 1'b1;
            if (wrap) begin
                act <= duty_in;
            end
        end
    end

    assign pwm = run && level_high(pos, act);

endmodule

// File: rtl/bl_pwm.sv
module bl_pwm
    import bl_pwm_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int PW = POS_W,
    parameter int VW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          pwm_out,
    output logic          bl_en
);

    div_reg_t      div_q;
    logic [DW-1:0] duty_q;
    logic [DW-1:0] bl_q;
    logic          run;
    logic [VW-1:0] div_f;
    logic [VW-1:0] pre_cnt;
    logic          tick;
    logic [PW-1:0] pos;
    logic [PW-1:0] act;

    bl_pwm_regfile #(.DW(DW)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .div_q  (div_q),
        .duty_q (duty_q),
        .bl_q   (bl_q),
        .rdata  (rdata)
    );

    assign run   = div_q.run;
    assign div_f = div_q.div;
    assign bl_en = bl_q[0];

    bl_pwm_prescaler #(.W(VW)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .div  (div_f),
        .cnt  (pre_cnt),
        .tick (tick)
    );

    bl_pwm_period #(.W(PW)) u_period (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .tick    (tick),
        .duty_in (PW'(duty_q)),
        .pos     (pos),
        .act     (act),
        .pwm     (pwm_out)
    );

endmodule

// File: rtl/bl_pwm_checker.sv
module bl_pwm_checker
    import bl_pwm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [7:0]       addr,
    input logic [7:0]       wdata,
    input logic             run,
    input logic [DIV_W-1:0] div_f,
    input logic [DIV_W-1:0] pre_cnt,
    input logic             tick,
    input logic [POS_W-1:0] pos,
    input logic [POS_W-1:0] act,
    input logic             pwm_out,
    input logic             bl_en
);

    assert_off_low_R8: assert property (@(posedge clk) disable iff (rst)
        !run |-> !pwm_out);

    assert_off_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pre_cnt == '0) && (pos == '0));

    assert_presc_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (run && $stable(div_f)) |-> (pre_cnt <= div_f));

    assert_pos_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> $stable(pos));

    assert_pos_step_R4: assert property (@(posedge clk) disable iff (rst)
        (run && tick) |=> (pos == $past(pos) + 1'b1));

    assert_act_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (run && !(tick && pos == {POS_W{1'b1}})) |=> $stable(act));

    assert_full_on_R5: assert property (@(posedge clk) disable iff (rst)
        (run && act == {POS_W{1'b1}}) |-> pwm_out);

    assert_bl_follow_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_BL) |=> (bl_en == $past(wdata[0])));

endmodule

bind bl_pwm bl_pwm_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .run     (run),
    .div_f   (div_f),
    .pre_cnt (pre_cnt),
    .tick    (tick),
    .pos     (pos),
    .act     (act),
    .pwm_out (pwm_out),
    .bl_en   (bl_en)
);

// File: tb/bl_pwm_bench.sv
`timescale 1ns/1ps
module bl_pwm_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       pwm_out;
    logic       bl_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference state, updated behaviourally per clock
    int m_ctl = 0;
    int m_duty = 0;
    int m_bl = 0;
    int m_pre = 0;
    int m_pos = 0;
    int m_act = 0;

    always #2.5 clk = ~clk;

    bl_pwm u_bl_pwm (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .pwm_out (pwm_out),
        .bl_en   (bl_en)
    );

    function automatic int exp_read(input int a);
        if (a == 'h4B) return m_ctl;
        if (a == 'h4E) return m_duty;
        if (a == 'h51) return m_bl;
        return 0;
    endfunction

    function automatic int exp_pwm();
        int running;
        running = (m_ctl >= 128);
        if (!running) return 0;
        if (m_act == 255) return 1;
        return (m_pos < m_act) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ctl = 0; m_duty = 0; m_bl = 0;
            m_pre = 0; m_pos = 0; m_act = 0;
        end else begin
            if (m_ctl < 128) begin
                m_pre = 0;
                m_pos = 0;
                m_act = m_duty;
            end else if (m_pre >= (m_ctl % 128)) begin
                m_pre = 0;
                if (m_pos == 255) begin
                    m_pos = 0;
                    m_act = m_duty;
                end else begin
                    m_pos = m_pos + 1;
                end
            end else begin
                m_pre = m_pre + 1;
            end
            if (wr_en) begin
                if (addr == 8'h4B) m_ctl = wdata;
                else if (addr == 8'h4E) m_duty = wdata;
                else if (addr == 8'h51) m_bl = wdata;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act_v, input int exp_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act_v, exp_v);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            check(pwm_out === 1'(exp_pwm()), cur_req, "pwm_out", int'(pwm_out), exp_pwm());
            check(bl_en === 1'(m_bl % 2), "R7", "bl_en", int'(bl_en), m_bl % 2);
            check(rdata === 8'(exp_read(int'(addr))), "R2", "rdata", int'(rdata), exp_read(int'(addr)));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input int e, input string req);
        @(posedge clk); #1;
        addr = a;
        #0.5;
        check(rdata === 8'(e), req, "read", int'(rdata), e);
    endtask

    task automatic high_count(input int cycles, input int e, input string req);
        int hi;
        hi = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
        check(hi == e, req, "high cycles", hi, e);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog run did not complete actual=1 expected=0");
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        cur_req = "R1";
        @(negedge clk);
        check(pwm_out === 1'b0, "R1", "pwm after reset", int'(pwm_out), 0);
        check(bl_en === 1'b0, "R1", "bl_en after reset", int'(bl_en), 0);
        rd_chk(8'h4B, 0, "R1");
        rd_chk(8'h4E, 0, "R1");
        rd_chk(8'h51, 0, "R1");

        // R4 R5: divide by 2, level 0x40
        cur_req = "R5";
        wr(8'h4E, 8'h40);
        wr(8'h4B, 8'h81);
        check(pwm_out === 1'b1, "R4", "first cycle of period high", int'(pwm_out), 1);
        high_count(512, 128, "R5");
        high_count(512, 128, "R4");

        // R2 read-back and unmapped addresses
        cur_req = "R2";
        wr(8'h51, 8'hA6);
        rd_chk(8'h4B, 'h81, "R2");
        rd_chk(8'h4E, 'h40, "R2");
        rd_chk(8'h51, 'hA6, "R2");
        rd_chk(8'h4C, 0, "R2");
        rd_chk(8'h00, 0, "R2");
        rd_chk(8'hFF, 0, "R2");

        // R7 backlight enable independent of PWM
        cur_req = "R7";
        wr(8'h51, 8'h01);
        @(negedge clk);
        check(bl_en === 1'b1, "R7", "bl_en set", int'(bl_en), 1);
        wr(8'h51, 8'h00);
        @(negedge clk);
        check(bl_en === 1'b0, "R7", "bl_en clear", int'(bl_en), 0);

        // R9 stop then restart with divide by 1
        cur_req = "R9";
        wr(8'h4B, 8'h00);
        check(pwm_out === 1'b0, "R9", "low right after stop", int'(pwm_out), 0);
        wr(8'h4B, 8'h80);
        check(pwm_out === 1'b1, "R9", "fresh period starts high", int'(pwm_out), 1);
        // R6 duty write mid-period, not applied until boundary
        cur_req = "R6";
        repeat (98) @(posedge clk);
        wr(8'h4E, 8'hC0);
        check(pwm_out === 1'b0, "R6", "old level kept mid-period", int'(pwm_out), 0);
        wr(8'h4B, 8'h00);
        wr(8'h4E, 8'h40);
        // R6 collision: duty write on the wrap edge
        wr(8'h4B, 8'h80);
        repeat (254) @(posedge clk);
        wr(8'h4E, 8'hC0);
        high_count(256, 64, "R6");
        high_count(256, 192, "R6");

        // R5 extremes
        cur_req = "R5";
        wr(8'h4B, 8'h00);
        wr(8'h4E, 8'hFF);
        wr(8'h4B, 8'h80);
        high_count(512, 512, "R5");
        wr(8'h4B, 8'h00);
        wr(8'h4E, 8'h00);
        wr(8'h4B, 8'h80);
        high_count(512, 0, "R5");

        // R8 disabled: duty writes follow at once, output held low
        cur_req = "R8";
        wr(8'h4B, 8'h05);
        high_count(40, 0, "R8");
        wr(8'h4E, 8'h80);
        wr(8'h4B, 8'h80);
        high_count(256, 128, "R8");

        // R10 shrink divider while running
        cur_req = "R10";
        wr(8'h4B, 8'h00);
        wr(8'h4E, 8'h20);
        wr(8'h4B, 8'h8A);
        repeat (7) @(posedge clk);
        wr(8'h4B, 8'h82);
        repeat (600) @(posedge clk);

        // R3 largest divider: period 32768 clocks
        cur_req = "R3";
        wr(8'h4B, 8'h00);
        wr(8'h4E, 8'h10);
        wr(8'h4B, 8'hFF);
        high_count(32768, 2048, "R3");

        // R1 reset mid-run
        cur_req = "R1";
        wr(8'h51, 8'h01);
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check(pwm_out === 1'b0, "R1", "pwm after mid reset", int'(pwm_out), 0);
        check(bl_en === 1'b0, "R1", "bl_en after mid reset", int'(bl_en), 0);
        rd_chk(8'h4B, 0, "R1");

        repeat (4) @(posedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule